// File: doc/BRIEF.md
# Dual-Band Zero-Crossing Tone Classifier

This block sits behind the band-split filters and limiters of a touch-tone receiver. It takes two 1-bit hard-limited signals: one carries the low (row) group and one the high (column) group. Both are sampled on a prescaled reference clock. For each band it counts clock ticks between successive rising transitions. It matches the resulting period against tick windows computed at elaboration for the four nominal tones of that band.

A band reports a tone only after a run of consecutive periods that all land in the same tone window. A period in another window, a period outside every window, or a long silence ends the report at once. The block raises a pair flag when each band reports exactly one tone. A downstream validator uses the flag to time tone duration and to encode the digit.

The clock input is the prescaled tick: one rising edge of `clk` is one tick of `TICK_HZ = REF_HZ / PRESCALE`. By default this is a 3.579545 MHz reference divided by 8.

Top module: `dual_tone_classifier`

## Requirements
- R1: After reset, row_hit, col_hit and pair_present are all 0.
- R2: A row-band period of P ticks matches row tone i when ceil(T*1000/(f*1025)) <= P <= floor(T*1000/(f*975)), with T = TICK_HZ and f the tone's frequency. The row tones are bit 0 = 697 Hz, bit 1 = 770 Hz, bit 2 = 852 Hz and bit 3 = 941 Hz of row_hit. The ±2.5 % window accepts every tone within ±(1.5 % + 2 Hz) of nominal and rejects every tone 3.5 % or more off nominal.
- R3: The column band uses the same window rule. Its tones are bit 0 = 1209 Hz, bit 1 = 1336 Hz, bit 2 = 1477 Hz and bit 3 = 1633 Hz of col_hit.
- R4: A band's hit bit rises only on the fourth consecutive period that matches the same tone. The first rising edge after reset or after a silence only starts timing. The bit is visible in the cycle after the clock edge that samples the rising transition ending that period.
- R5: A period that matches a different tone, or no tone at all, clears that band's hit in the cycle after the clock edge that ends the period.
- R6: If no rising transition arrives within LIMIT = TICK_HZ / FLOOR_HZ ticks of the last one, that band's hit clears. Before that point the hit holds.
- R7: pair_present is 1 exactly when row_hit has one bit set and col_hit has one bit set.
- R8: Neither row_hit nor col_hit ever has more than one bit set.
- R9: The two bands are classified independently. Any row tone combines with any column tone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaled tick clock |
| rst | input | 1 | Synchronous active-high reset |
| low_bit | input | 1 | Hard-limited row-band signal |
| high_bit | input | 1 | Hard-limited column-band signal |
| row_hit | output | 4 | One-hot qualified row tone |
| col_hit | output | 4 | One-hot qualified column tone |
| pair_present | output | 1 | One tone held in each band |

## Verification
The embedded assertions check every cycle that each hit vector stays one-hot or zero and that the period counter never passes its limit. They also check that a timeout or an unmatched period leaves the hit cleared on the next cycle, that a hit only appears right after a completed period, and that the pair flag never stands without a tone in both bands.

The window edges, the exact cycle of qualification on the fourth period, a switch between tones, and the hold-then-clear behaviour across a silence show up only in the bench scenarios. The bench sweeps every integer period across both bands and runs all sixteen row/column combinations, comparing against windows computed arithmetically.

// File: rtl/dtone_pkg.sv
package dtone_pkg;
  localparam int TONES_PER_BAND = 4;

  typedef struct packed {
    logic                      done;   // a full period just ended
    logic                      stall;  // silence reached the limit
    logic [TONES_PER_BAND-1:0] match;  // window hit for the period that ended
  } bandEvt_t;

  // Shortest accepted period: frequency 2.5 % above nominal, rounded up.
  function automatic int tickLo(input int tickHz, input int toneHz);
    longint num;
    longint den;
    num = longint'(tickHz) * 1000;
    den = longint'(toneHz) * 1025;
    return int'((num + den - 1) / den);
  endfunction

  // Longest accepted period: frequency 2.5 % below nominal, rounded down.
  function automatic int tickHi(input int tickHz, input int toneHz);
    longint num;
    longint den;
    num = longint'(tickHz) * 1000;
    den = longint'(toneHz) * 975;
    return int'(num / den);
  endfunction
endpackage

// File: rtl/tone_period_path.sv
module tone_period_path
  import dtone_pkg::*;
#(
  parameter int TICK_HZ = 447443,
  parameter int LIMIT   = 894,
  parameter int CW      = 10,
  parameter logic [16*TONES_PER_BAND-1:0] TONES = '0
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bitIn,
  output bandEvt_t evt
);
  logic          prevQ;
  logic          armedQ;
  logic [CW-1:0] cntQ;
  logic          rise;

  assign rise      = bitIn & ~prevQ;
  assign evt.done  = rise & armedQ;
  assign evt.stall = armedQ & ~rise & (cntQ == CW'(LIMIT));

  always_ff @(posedge clk) begin
    if (rst) begin
      prevQ  <= 1'b0;
      armedQ <= 1'b0;
      cntQ   <= '0;
    end else begin
      prevQ <= bitIn;
      if (rise) begin
        armedQ <= 1'b1;
        cntQ   <= CW'(1);
      end else begin
        if (cntQ != CW'(LIMIT)) cntQ <= cntQ + CW'(1);
        if (evt.stall) armedQ <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < TONES_PER_BAND; i++) begin : g_window
    localparam int TONE_HZ = int'(TONES[16*i +: 16]);
    localparam logic [CW-1:0] LO = CW'(tickLo(TICK_HZ, TONE_HZ));
    localparam logic [CW-1:0] HI = CW'(tickHi(TICK_HZ, TONE_HZ));
    assign evt.match[i] = evt.done & (cntQ >= LO) & (cntQ <= HI);
  end

  assert_cnt_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    cntQ <= CW'(LIMIT));
  assert_single_window_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(evt.match));
endmodule

// File: rtl/tone_hit_ctrl.sv
module tone_hit_ctrl
  import dtone_pkg::*;
#(
  parameter int QUAL = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  bandEvt_t                  evt,
  output logic [TONES_PER_BAND-1:0] hit
);
  localparam int RW = $clog2(QUAL + 1);

  logic [RW-1:0]             runQ;
  logic [RW-1:0]             runNext;
  logic [TONES_PER_BAND-1:0] lastQ;
  logic                      sameTone;

  assign sameTone = (evt.match == lastQ) && (runQ != '0);

  always_comb begin
    if (!sameTone)               runNext = RW'(1);
    else if (runQ == RW'(QUAL))  runNext = runQ;
    else                         runNext = runQ + RW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || evt.stall) begin
      runQ  <= '0;
      lastQ <= '0;
      hit   <= '0;
    end else if (evt.done) begin
      if (evt.match == '0) begin
        runQ  <= '0;
        lastQ <= '0;
        hit   <= '0;
      end else begin
        runQ  <= runNext;
        lastQ <= evt.match;
        hit   <= (runNext == RW'(QUAL)) ? evt.match : '0;
      end
    end
  end

  assert_hit_onehot_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit));
  assert_stall_clears_R6: assert property (@(posedge clk) disable iff (rst)
    evt.stall |=> (hit == '0));
  assert_miss_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (evt.done && evt.match == '0) |=> (hit == '0));
  assert_rise_after_period_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(|hit) |-> $past(evt.done));
endmodule

// File: rtl/dual_tone_classifier.sv
module dual_tone_classifier
  import dtone_pkg::*;
#(
  parameter int REF_HZ   = 3579545,
  parameter int PRESCALE = 8,
  parameter int FLOOR_HZ = 500,
  parameter int QUAL     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       low_bit,
  input  logic       high_bit,
  output logic [3:0] row_hit,
  output logic [3:0] col_hit,
  output logic       pair_present
);
  localparam int TICK_HZ = REF_HZ / PRESCALE;
  localparam int LIMIT   = TICK_HZ / FLOOR_HZ;
  localparam int CW      = $clog2(LIMIT + 1);
  localparam logic [63:0] ROW_TONES = {16'd941, 16'd852, 16'd770, 16'd697};
  localparam logic [63:0] COL_TONES = {16'd1633, 16'd1477, 16'd1336, 16'd1209};

  logic                      bandBit [2];
  logic [TONES_PER_BAND-1:0] bandHit [2];
  bandEvt_t                  bandEvt [2];

  assign bandBit[0] = low_bit;
  assign bandBit[1] = high_bit;

  for (genvar b = 0; b < 2; b++) begin : g_band
    tone_period_path #(
      .TICK_HZ(TICK_HZ), .LIMIT(LIMIT), .CW(CW),
      .TONES(b == 0 ? ROW_TONES : COL_TONES)
    ) path_i (
      .clk(clk), .rst(rst), .bitIn(bandBit[b]), .evt(bandEvt[b])
    );
    tone_hit_ctrl #(.QUAL(QUAL)) ctrl_i (
      .clk(clk), .rst(rst), .evt(bandEvt[b]), .hit(bandHit[b])
    );
  end

  assign row_hit      = bandHit[0];
  assign col_hit      = bandHit[1];
  assign pair_present = $onehot(row_hit) && $onehot(col_hit);

  assert_pair_needs_both_R7: assert property (@(posedge clk) disable iff (rst)
    pair_present |-> (row_hit != '0 && col_hit != '0));
endmodule

// File: tb/dual_tone_classifier_tb_top.sv
module dual_tone_classifier_tb_top;
  localparam int TICK = 100000;   // 800 kHz reference / 8
  localparam int LIM  = TICK / 500;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lowBit = 1'b0;
  logic       highBit = 1'b0;
  logic [3:0] rowHit, colHit;
  logic       pairPresent;
  int checks = 0;
  int failures = 0;
  int rowHz [4] = '{697, 770, 852, 941};
  int colHz [4] = '{1209, 1336, 1477, 1633};
  int rowP  [4] = '{143, 130, 117, 106};
  int colP  [4] = '{83, 75, 68, 61};

  always #5 clk = ~clk;

  dual_tone_classifier #(.REF_HZ(800000), .PRESCALE(8), .FLOOR_HZ(500), .QUAL(4)) dut_i (
    .clk(clk), .rst(rst), .low_bit(lowBit), .high_bit(highBit),
    .row_hit(rowHit), .col_hit(colHit), .pair_present(pairPresent)
  );

  function automatic logic [3:0] expMask(input int p, input int hz [4]);
    logic [3:0] m = '0;
    for (int i = 0; i < 4; i++) begin
      longint lo = (longint'(TICK) * 1000 + longint'(hz[i]) * 1025 - 1) / (longint'(hz[i]) * 1025);
      longint hi = (longint'(TICK) * 1000) / (longint'(hz[i]) * 975);
      if (p >= lo && p <= hi) m[i] = 1'b1;
    end
    return m;
  endfunction

  task automatic applyReset();
    @(negedge clk);
    rst = 1'b1; lowBit = 1'b0; highBit = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runWave(input int pl, input int ph, input int start, input int n);
    for (int k = 0; k < n; k++) begin
      int c = start + k;
      @(negedge clk);
      lowBit  = (pl == 0) ? 1'b0 : ((c % pl) < pl / 2);
      highBit = (ph == 0) ? 1'b0 : ((c % ph) < ph / 2);
    end
  endtask

  task automatic sampleEdge();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    applyReset();
    sampleEdge();
    check("R1 reset", {rowHit, colHit, pairPresent}, 9'h000);

    // R4: three periods do not qualify, the fourth does
    applyReset();
    runWave(143, 0, 0, 4 * 143);
    sampleEdge();
    check("R4 three periods", {rowHit, colHit, pairPresent}, 9'h000);
    runWave(143, 0, 572, 1);
    sampleEdge();
    check("R4 fourth period", {rowHit, colHit, pairPresent}, {4'b0001, 4'b0000, 1'b0});

    // R5: a different tone clears, then qualifies anew
    runWave(130, 0, 0, 262);
    sampleEdge();
    check("R5 tone change clears", {5'b0, rowHit}, 9'h000);
    runWave(130, 0, 262, 389);
    sampleEdge();
    check("R5 new tone qualifies", {5'b0, rowHit}, 9'h002);
    // R5: a period outside every window clears
    runWave(100, 0, 0, 101);
    sampleEdge();
    check("R5 out of range clears", {5'b0, rowHit}, 9'h000);

    // R6: silence holds, then clears after the limit
    applyReset();
    runWave(143, 83, 0, 5 * 143 + 3);
    sampleEdge();
    check("R7 pair with both bands", {rowHit, colHit, pairPresent}, {4'b0001, 4'b0001, 1'b1});
    runWave(0, 0, 0, 150);
    sampleEdge();
    check("R6 hold before limit, col past limit", {rowHit, colHit, pairPresent},
          {4'b0001, 4'b0000, 1'b0});
    runWave(0, 0, 0, LIM - 150 + 10);
    sampleEdge();
    check("R6 cleared after limit", {rowHit, colHit, pairPresent}, 9'h000);

    // R9 / R7: every row/column combination
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        applyReset();
        runWave(rowP[i], colP[j], 0, 5 * rowP[i] + 1);
        sampleEdge();
        check("R9 combination", {rowHit, colHit, pairPresent},
              {4'(1 << i), 4'(1 << j), 1'b1});
      end
    end

    // R2 / R3: sweep every integer period across both bands
    for (int p = 58; p <= 150; p++) begin
      applyReset();
      runWave(p, p, 0, 5 * p + 1);
      sampleEdge();
      check("R2 row window", {5'b0, rowHit}, {5'b0, expMask(p, rowHz)});
      check("R3 col window", {5'b0, colHit}, {5'b0, expMask(p, colHz)});
      check("R7 single band no pair", {8'b0, pairPresent}, 9'h000);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule